// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address. It walks a sparse two-level page table that lives in word-addressed main memory. A processor-side request carries the virtual address. At the moment the request is accepted, the walker latches the frame number of the current process's top-level table. It then reads the top-level entry, follows it to a second-level table, and reads the leaf entry. Finally it returns a response that holds either the physical address or a fault flag together with the faulting virtual address.

Pages are 4 KB. The virtual page number is split into two 10-bit indices, and every table entry is a 32-bit word. An entry holds a 20-bit frame number in bits [31:12] and a present flag in bit 0. A top-level entry whose present flag is clear marks a region with no second-level table. The walk then ends after a single memory read. The memory port is a plain read channel whose ready may stay low for any number of cycles.

Top module: `ptw_top`

## Requirements
- R1: After reset the walker is idle: req_ready is 1, while mem_valid and resp_valid are 0.
- R2: A request is accepted only while the walker is idle. req_ready is 0 from acceptance until the response has been consumed.
- R3: The first read goes to word address {root frame, vaddr[31:22]}, which is 30 bits wide.
- R4: While mem_valid is 1 and mem_ready is 0, mem_valid stays 1 and mem_addr does not change.
- R5: A top-level entry with bit 0 clear ends the walk after exactly one memory read. The response then has resp_fault = 1, resp_vaddr = the requested address and resp_paddr = 0.
- R6: For a present top-level entry, the second read goes to word address {entry[31:12], vaddr[21:12]}.
- R7: A leaf entry with bit 0 clear gives resp_fault = 1, resp_vaddr = the requested address and resp_paddr = 0, after exactly two reads.
- R8: A present leaf entry gives resp_fault = 0 and resp_paddr = {leaf[31:12], vaddr[11:0]}, after exactly two reads.
- R9: resp_valid and the response fields stay unchanged until resp_ready is 1. The walker is then idle in the next cycle.
- R10: The root frame is sampled when the request is accepted. Changes to root_frame during a walk do not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| root_frame | input | 20 | Frame number of the current top-level table |
| resp_valid | output | 1 | Response available |
| resp_ready | input | 1 | Response consumed |
| resp_fault | output | 1 | Translation failed |
| resp_paddr | output | 32 | Physical address, 0 on fault |
| resp_vaddr | output | 32 | Virtual address of the walk |
| mem_valid | output | 1 | Memory read request |
| mem_ready | input | 1 | Read data valid this cycle |
| mem_addr | output | 30 | Word address of the read |
| mem_rdata | input | 32 | Read data |

## Verification
The walker is driven with a few hundred random virtual addresses and root frames against a hashed memory image. In that image about a quarter of entries are absent at each level, so null top entries, absent leaves and full translations are all exercised. Directed walks cover three further cases. A null top entry that is all-zero and one that has a nonzero frame but bit 0 clear both show that only bit 0 decides presence. The extreme addresses 0 and all-ones catch index and offset slicing errors. A long memory stall and a changing root frame during a walk separate the behaviour that holds inputs stable from the behaviour that samples them. The bench counts memory reads on every walk, and the count tells a one-read early exit apart from a full two-level walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 10;
    localparam int PTE_W     = 32;
    localparam int FRAME_W   = VA_W - OFF_W;
    localparam int WADDR_W   = VA_W - 2;
    localparam int RSVD_W    = PTE_W - FRAME_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_L1,
        ST_READ_L2,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [RSVD_W-1:0]  rsvd;
        logic               present;
    } pte_t;

    function automatic logic [IDX_W-1:0] top_index(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] leaf_index(input logic [VA_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic logic [OFF_W-1:0] page_offset(input logic [VA_W-1:0] va);
        return va[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0]   raw,
    output logic               present,
    output logic [FRAME_W-1:0] frame
);
    pte_t entry;

    always_comb begin
        entry   = pte_t'(raw);
        present = entry.present;
        frame   = entry.frame;
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  walk_state_e        state,
    input  logic [VA_W-1:0]    va,
    input  logic [FRAME_W-1:0] root,
    input  logic [FRAME_W-1:0] table2,
    output logic [WADDR_W-1:0] word_addr
);
    always_comb begin
        if (state == ST_READ_L2) begin
            word_addr = {table2, leaf_index(va)};
        end else begin
            word_addr = {root, top_index(va)};
        end
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               resp_ready,
    input  logic               mem_ready,
    input  logic               pte_present,
    input  logic [FRAME_W-1:0] pte_frame,
    output walk_state_e        state,
    output logic [VA_W-1:0]    va_q,
    output logic [FRAME_W-1:0] root_q,
    output logic [FRAME_W-1:0] table2_q,
    output logic [VA_W-1:0]    paddr_q
);
    walk_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req_valid) nxt = ST_READ_L1;
            ST_READ_L1: if (mem_ready) nxt = pte_present ? ST_READ_L2 : ST_FAULT;
            ST_READ_L2: if (mem_ready) nxt = pte_present ? ST_DONE : ST_FAULT;
            ST_DONE,
            ST_FAULT:   if (resp_ready) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            va_q     <= '0;
            root_q   <= '0;
            table2_q <= '0;
            paddr_q  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && req_valid) begin
                va_q    <= req_vaddr;
                root_q  <= root_frame;
                paddr_q <= '0;
            end
            if (state == ST_READ_L1 && mem_ready && pte_present) begin
                table2_q <= pte_frame;
            end
            if (state == ST_READ_L2 && mem_ready && pte_present) begin
                paddr_q <= {pte_frame, page_offset(va_q)};
            end
        end
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] root_frame,
    output logic               resp_valid,
    input  logic               resp_ready,
    output logic               resp_fault,
    output logic [VA_W-1:0]    resp_paddr,
    output logic [VA_W-1:0]    resp_vaddr,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [WADDR_W-1:0] mem_addr,
    input  logic [PTE_W-1:0]   mem_rdata
);
    walk_state_e        state;
    logic [VA_W-1:0]    va_q;
    logic [FRAME_W-1:0] root_q;
    logic [FRAME_W-1:0] table2_q;
    logic [VA_W-1:0]    paddr_q;
    logic               pte_present;
    logic [FRAME_W-1:0] pte_frame;

    ptw_pte_dec u_dec (
        .raw     (mem_rdata),
        .present (pte_present),
        .frame   (pte_frame)
    );

    ptw_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_vaddr   (req_vaddr),
        .root_frame  (root_frame),
        .resp_ready  (resp_ready),
        .mem_ready   (mem_ready),
        .pte_present (pte_present),
        .pte_frame   (pte_frame),
        .state       (state),
        .va_q        (va_q),
        .root_q      (root_q),
        .table2_q    (table2_q),
        .paddr_q     (paddr_q)
    );

    ptw_addr_gen u_agen (
        .state     (state),
        .va        (va_q),
        .root      (root_q),
        .table2    (table2_q),
        .word_addr (mem_addr)
    );

    assign req_ready  = (state == ST_IDLE);
    assign mem_valid  = (state == ST_READ_L1) || (state == ST_READ_L2);
    assign resp_valid = (state == ST_DONE) || (state == ST_FAULT);
    assign resp_fault = (state == ST_FAULT);
    assign resp_paddr = paddr_q;
    assign resp_vaddr = va_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_ready,
    input logic               resp_fault,
    input logic [VA_W-1:0]    resp_paddr,
    input logic [VA_W-1:0]    resp_vaddr,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic [WADDR_W-1:0] mem_addr
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !mem_valid && !resp_valid)); // R1

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (mem_valid || resp_valid) |-> !req_ready); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R4

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=>
            (resp_valid && $stable(resp_fault) && $stable(resp_paddr) && $stable(resp_vaddr))); // R9

    AST_RESP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_ready) |=> (req_ready && !resp_valid)); // R9

    AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (resp_paddr == '0)); // R7
endmodule

bind ptw_top ptw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_fault (resp_fault),
    .resp_paddr (resp_paddr),
    .resp_vaddr (resp_vaddr),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr)
);

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [19:0] root_frame = '0;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic        resp_fault;
    logic [31:0] resp_paddr;
    logic [31:0] resp_vaddr;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [29:0] mem_addr;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int reads  = 0;
    int stall_left = 0;
    int cyc = 0;
    bit finished = 1'b0;
    bit prev_stall = 1'b0;
    logic [29:0] prev_addr = '0;
    logic [31:0] ovr [int unsigned];

    always #2.5 clk = ~clk;

    ptw_top u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] memrd(input logic [29:0] a);
        logic [31:0] h;
        if (ovr.exists(int'(a))) return ovr[int'(a)];
        h = {2'b00, a} * 32'h9E3779B1;
        h = h ^ (h >> 15);
        h = h * 32'h85EBCA6B;
        h = h ^ (h >> 13);
        return {h[31:1], h[1] | h[2]};
    endfunction

    task automatic expect_walk(input logic [31:0] va, input logic [19:0] root,
                               output bit flt, output logic [31:0] pa, output int nrd,
                               output logic [29:0] a1, output logic [29:0] a2);
        logic [31:0] e1, e2;
        a1 = {root, va[31:22]};
        e1 = memrd(a1);
        a2 = {e1[31:12], va[21:12]};
        pa = 32'h0;
        if (!e1[0]) begin
            flt = 1'b1; nrd = 1;
        end else begin
            e2 = memrd(a2);
            nrd = 2;
            flt = !e2[0];
            if (e2[0]) pa = {e2[31:12], va[11:0]};
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (mem_valid && mem_ready) reads++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                chk(mem_valid && mem_addr == prev_addr, "R4 stall hold", {2'b0, mem_addr}, {2'b0, prev_addr});
            end
            if (stall_left > 0) begin
                mem_ready = 1'b0;
                stall_left--;
            end else begin
                mem_ready = ($urandom % 4) != 0;
            end
            mem_rdata  = memrd(mem_addr);
            prev_stall = mem_valid && !mem_ready;
            prev_addr  = mem_addr;
        end
    end

    task automatic walk(input logic [31:0] va, input logic [19:0] root);
        bit flt;
        logic [31:0] pa;
        int nrd;
        logic [29:0] a1, a2;
        expect_walk(va, root, flt, pa, nrd, a1, a2);
        @(negedge clk);
        req_valid  = 1'b1;
        req_vaddr  = va;
        root_frame = root;
        reads = 0;
        @(posedge clk);
        chk(req_ready == 1'b1, "R2 idle accept", {31'b0, req_ready}, 32'h1);
        @(negedge clk);
        req_valid  = 1'b0;
        req_vaddr  = $urandom;
        root_frame = 20'($urandom); // R10: must not disturb this walk
        while (!resp_valid) begin
            chk(req_ready == 1'b0, "R2 busy", {31'b0, req_ready}, 32'h0);
            if (mem_valid) begin
                if (reads == 0) chk(mem_addr == a1, "R3 top addr", {2'b0, mem_addr}, {2'b0, a1});
                else            chk(mem_addr == a2, "R6 leaf addr", {2'b0, mem_addr}, {2'b0, a2});
            end
            @(negedge clk);
        end
        chk(resp_fault == flt, flt ? (nrd == 1 ? "R5 fault" : "R7 fault") : "R8 fault",
            {31'b0, resp_fault}, {31'b0, flt});
        chk(resp_vaddr == va, "R10 vaddr", resp_vaddr, va);
        chk(resp_paddr == pa, flt ? "R7 paddr" : "R8 paddr", resp_paddr, pa);
        chk(reads == nrd, nrd == 1 ? "R5 reads" : "R8 reads", reads, nrd);
        for (int i = 0; i < int'($urandom % 3); i++) begin
            @(negedge clk);
            chk(resp_valid && resp_paddr == pa && resp_fault == flt, "R9 hold", resp_paddr, pa);
        end
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        chk(req_ready && !resp_valid, "R9 release", {30'b0, req_ready, resp_valid}, 32'h2);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !mem_valid && !resp_valid, "R1 reset",
            {29'b0, req_ready, mem_valid, resp_valid}, 32'h4);

        // R5: all-zero null top entry
        ovr[int'({20'h00012, 10'h3FF})] = 32'h0;
        walk(32'hFFC0_0123, 20'h00012);
        // R5: nonzero frame but bit 0 clear
        ovr[int'({20'h00013, 10'h001})] = 32'hABCDE000;
        walk(32'h0040_0ABC, 20'h00013);
        // R7: leaf absent
        ovr[int'({20'h00014, 10'h000})] = 32'h22222001;
        ovr[int'({20'h22222, 10'h000})] = 32'h33333FFE;
        walk(32'h0000_0FFF, 20'h00014);
        // R8: extremes
        ovr[int'({20'h00015, 10'h000})] = 32'h44444001;
        ovr[int'({20'h44444, 10'h000})] = 32'h55555001;
        walk(32'h0000_0000, 20'h00015);
        ovr[int'({20'hFFFFF, 10'h3FF})] = 32'hFFFFF001;
        ovr[int'({20'hFFFFF, 10'h3FF})] = 32'hFFFFF001;
        walk(32'hFFFF_FFFF, 20'hFFFFF);
        // R4: long stall on a full walk
        stall_left = 25;
        walk(32'h0000_0000, 20'h00015);

        for (int n = 0; n < 300; n++) begin
            walk($urandom, 20'($urandom));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule